// File: doc/BRIEF.md
# Masked Priority Interrupt Arbiter

This block gathers interrupt requests from a parameterised number of sources, each of which carries its own two-bit priority level. Every cycle it picks the pending request with the highest level, settling ties in favour of the lowest source number. It then weighs that level against the processor's current two-bit interrupt mask and, when the winner is allowed through, raises one combined request line toward the core's interrupt control logic. The winning source number and its level travel with that line so that the core can form a vector.

The core owns everything that happens after the line rises: fetching the vector, saving context and raising the mask. The arbiter keeps no memory of past winners. A source that drops its request simply stops competing from the next sampled cycle onward. Outputs are registered, so a change on the inputs shows at the outputs exactly one clock edge later.

A small two-state machine holds the output line. In `ARB_QUIET` no request is presented. In `ARB_RAISED` the request line is high and the source and level fields are valid. On every edge the transition `quiet_to_raised` or `raised_to_raised` is taken when a winner passes the mask. The transition `raised_to_quiet` or `quiet_to_quiet` is taken when no winner passes it.

Top module: `irq_mask_arbiter`

## Requirements
- R1: While reset is held and after its release, until the first sampling edge, `irq_o` is 0 and `irq_src_o` and `irq_lvl_o` are 0.
- R2: The outputs after a rising clock edge are a function only of `req_i`, `prio_i` and `mask_i` as sampled at that edge, which gives one cycle of latency. Between edges the outputs do not change.
- R3: Among sources with `req_i[i]` = 1, the winner is a source with the numerically largest level. The level of source i is `prio_i[2i+1:2i]`, where 0 is the lowest and 3 the highest.
- R4: When several pending sources share the largest level, the winner is the one with the lowest index.
- R5: A winner of level 0, 1 or 2 raises `irq_o` only when its level is strictly greater than `mask_i`. `mask_i` is read as an unsigned value 0..3, with bit 1 as the upper mask bit and bit 0 as the lower.
- R6: A winner of level 3 raises `irq_o` whatever the value of `mask_i`.
- R7: When `irq_o` is 1, `irq_src_o` holds the winner's index and `irq_lvl_o` holds its level. When no request is pending, or the winner is blocked, `irq_o`, `irq_src_o` and `irq_lvl_o` are all 0.
- R8: A source whose request bit falls to 0 takes no part in the decision sampled at that edge, even if it won on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_SRC | Request bit per source |
| prio_i | input | 2*NUM_SRC | Two-bit level per source, source i in bits 2i+1:2i |
| mask_i | input | 2 | Current core interrupt mask level |
| irq_o | output | 1 | Combined enabled request toward the core |
| irq_src_o | output | $clog2(NUM_SRC) | Index of the forwarded source |
| irq_lvl_o | output | 2 | Level of the forwarded source |

## Verification
Random request sets with random levels and mask values cover most combinations of winner level against mask. These separate a correct strict comparison from an off-by-one or non-strict one. Directed patterns put several sources on the same top level, to expose a wrong tie order. They also present level 3 under the highest mask, which tells a non-maskable path apart from a plain comparison. A winner that is withdrawn for one cycle shows whether stale state lingers. Observing the outputs before and after the edge that follows an input change pins the latency to one cycle, not zero or two.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int LVL_W  = 2;
    localparam int LVL_NMI = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic {
        ARB_QUIET  = 1'b0,
        ARB_RAISED = 1'b1
    } arb_state_e;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]       req,
    input  logic [NUM_SRC*LVL_W-1:0] prio,
    output logic                     any,
    output logic [IDX_W-1:0]         idx,
    output lvl_t                     lvl
);

    lvl_t src_lvl [NUM_SRC];

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_split
            assign src_lvl[g] = prio[g*LVL_W +: LVL_W];
        end
    endgenerate

    // Linear scan from index 0 upward; a later source only displaces the
    // current best with a strictly higher level, so ties keep the lowest index.
    always_comb begin
        any = 1'b0;
        idx = '0;
        lvl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && (!any || (src_lvl[i] > lvl))) begin
                any = 1'b1;
                idx = IDX_W'(i);
                lvl = src_lvl[i];
            end
        end
    end

endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate
    import irq_arb_pkg::*;
(
    input  logic any,
    input  lvl_t lvl,
    input  lvl_t mask,
    output logic pass
);

    logic nmi_lvl;

    assign nmi_lvl = (lvl == lvl_t'(LVL_NMI));
    assign pass    = any && (nmi_lvl || (lvl > mask));

endmodule

// File: rtl/irq_mask_arbiter.sv
module irq_mask_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       req_i,
    input  logic [NUM_SRC*LVL_W-1:0] prio_i,
    input  logic [LVL_W-1:0]         mask_i,
    output logic                     irq_o,
    output logic [IDX_W-1:0]         irq_src_o,
    output logic [LVL_W-1:0]         irq_lvl_o
);

    logic             win_any;
    logic [IDX_W-1:0] win_idx;
    lvl_t             win_lvl;
    logic             win_pass;

    arb_state_e       state_q, state_d;
    logic [IDX_W-1:0] src_q, src_d;
    lvl_t             lvl_q, lvl_d;

    irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req  (req_i),
        .prio (prio_i),
        .any  (win_any),
        .idx  (win_idx),
        .lvl  (win_lvl)
    );

    irq_mask_gate u_gate (
        .any  (win_any),
        .lvl  (win_lvl),
        .mask (mask_i),
        .pass (win_pass)
    );

    // Next-state and captured fields
    always_comb begin
        state_d = ARB_QUIET;
        src_d   = '0;
        lvl_d   = '0;
        unique case (state_q)
            ARB_QUIET, ARB_RAISED: begin
                if (win_pass) begin
                    state_d = ARB_RAISED;
                    src_d   = win_idx;
                    lvl_d   = win_lvl;
                end
            end
            default: state_d = ARB_QUIET;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_QUIET;
            src_q   <= '0;
            lvl_q   <= '0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            lvl_q   <= lvl_d;
        end
    end

    // Outputs
    always_comb begin
        irq_o     = 1'b0;
        irq_src_o = '0;
        irq_lvl_o = '0;
        unique case (state_q)
            ARB_RAISED: begin
                irq_o     = 1'b1;
                irq_src_o = src_q;
                irq_lvl_o = lvl_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_mask_arbiter_chk.sv
module irq_mask_arbiter_chk
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_SRC-1:0]       req_i,
    input logic [NUM_SRC*LVL_W-1:0] prio_i,
    input logic [LVL_W-1:0]         mask_i,
    input logic                     irq_o,
    input logic [IDX_W-1:0]         irq_src_o,
    input logic [LVL_W-1:0]         irq_lvl_o
);

    logic [NUM_SRC-1:0]       req_s;
    logic [NUM_SRC*LVL_W-1:0] prio_s;
    lvl_t                     mask_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_s  <= '0;
            prio_s <= '0;
            mask_s <= '0;
        end else begin
            req_s  <= req_i;
            prio_s <= prio_i;
            mask_s <= mask_i;
        end
    end

    assert_rst_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && irq_src_o == '0 && irq_lvl_o == '0));

    assert_src_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> req_s[irq_src_o]);

    assert_lvl_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_lvl_o == prio_s[irq_src_o*LVL_W +: LVL_W]));

    assert_mask_honoured_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((irq_lvl_o == lvl_t'(LVL_NMI)) || (irq_lvl_o > mask_s)));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_src_o == '0 && irq_lvl_o == '0));

    assert_none_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_s == '0) |-> !irq_o);

endmodule

bind irq_mask_arbiter irq_mask_arbiter_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/irq_mask_arbiter_test.sv
module irq_mask_arbiter_test;

    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_i = '0;
    logic [2*N-1:0]  prio_i = '0;
    logic [1:0]      mask_i = '0;
    logic            irq_o;
    logic [IW-1:0]   irq_src_o;
    logic [1:0]      irq_lvl_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irq_mask_arbiter #(.NUM_SRC(N)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_i(prio_i),
        .mask_i(mask_i), .irq_o(irq_o), .irq_src_o(irq_src_o), .irq_lvl_o(irq_lvl_o)
    );

    always #10 clk = ~clk;

    logic          exp_irq;
    logic [IW-1:0] exp_src;
    logic [1:0]    exp_lvl;

    task automatic model(input logic [N-1:0] r, input logic [2*N-1:0] p, input logic [1:0] m);
        logic found = 1'b0;
        int   bi = 0;
        int   bl = 0;
        for (int i = 0; i < N; i++) begin
            int l = int'(p[2*i +: 2]);
            if (r[i] && (!found || l > bl)) begin
                found = 1'b1; bi = i; bl = l;
            end
        end
        if (found && (bl == 3 || bl > int'(m))) begin
            exp_irq = 1'b1; exp_src = IW'(bi); exp_lvl = 2'(bl);
        end else begin
            exp_irq = 1'b0; exp_src = '0; exp_lvl = '0;
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (irq_o !== exp_irq || irq_src_o !== exp_src || irq_lvl_o !== exp_lvl) begin
            errors++;
            $display("FAIL %s: got irq=%b src=%0d lvl=%0d, expected irq=%b src=%0d lvl=%0d",
                     tag, irq_o, irq_src_o, irq_lvl_o, exp_irq, exp_src, exp_lvl);
        end
    endtask

    // Drive at a falling edge, sample at the following falling edge.
    task automatic apply(input logic [N-1:0] r, input logic [2*N-1:0] p,
                         input logic [1:0] m, input string tag);
        req_i = r; prio_i = p; mask_i = m;
        model(r, p, m);
        @(negedge clk);
        check(tag);
    endtask

    function automatic logic [2*N-1:0] lv(input int src, input int l, input logic [2*N-1:0] base);
        logic [2*N-1:0] v = base;
        v[2*src +: 2] = 2'(l);
        return v;
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state, with requests present during reset
        req_i = '1; prio_i = '1; mask_i = 2'd0;
        repeat (3) @(negedge clk);
        exp_irq = 0; exp_src = 0; exp_lvl = 0;
        check("R1 during reset");
        rst_n = 1'b1;
        req_i = '0;
        #2;
        check("R1 after release before edge");
        @(negedge clk);

        // R2: latency - inputs change, outputs hold until the next edge
        req_i = 8'b0000_0100; prio_i = lv(2, 2, '0); mask_i = 2'd0;
        exp_irq = 0; exp_src = 0; exp_lvl = 0;
        #5; check("R2 no change before edge");
        model(req_i, prio_i, mask_i);
        @(negedge clk); check("R2 one edge later");

        // R3: highest level wins
        apply(8'b1010_0110, lv(7,1, lv(5,3, lv(2,2, lv(1,1,'0)))), 2'd0, "R3 highest level");
        // R4: ties go to lowest index
        apply(8'b1011_0000, lv(7,2, lv(5,2, lv(4,2,'0))), 2'd0, "R4 tie lowest index");
        apply(8'b1000_0001, lv(7,3, lv(0,3,'0)), 2'd3, "R4 tie at level 3");
        // R5: strict comparison
        apply(8'b0000_1000, lv(3,2,'0), 2'd2, "R5 equal level blocked");
        apply(8'b0000_1000, lv(3,2,'0), 2'd1, "R5 higher level passes");
        apply(8'b0000_0001, '0, 2'd0, "R5 level 0 never passes");
        // R6: level 3 under highest mask
        apply(8'b0100_0000, lv(6,3,'0), 2'd3, "R6 level 3 under mask 3");
        // R7: no requests
        apply(8'b0000_0000, '1, 2'd0, "R7 idle zero");
        // R8: withdrawn winner
        apply(8'b0001_0010, lv(4,3, lv(1,1,'0)), 2'd0, "R8 before withdraw");
        apply(8'b0000_0010, lv(4,3, lv(1,1,'0)), 2'd0, "R8 winner withdrawn");
        apply(8'b0001_0010, lv(4,3, lv(1,1,'0)), 2'd0, "R8 request returns");

        // Random mix: R3, R4, R5, R6, R7
        for (int k = 0; k < 400; k++) begin
            logic [N-1:0]   r = N'($urandom);
            logic [2*N-1:0] p = (2*N)'($urandom);
            logic [1:0]     m = 2'($urandom);
            if (k % 5 == 0) r = r & N'($urandom);
            apply(r, p, m, "R3 random arbitration");
        end

        // R1: reset mid-run clears outputs
        apply(8'b1111_1111, '1, 2'd0, "R6 before reset");
        rst_n = 1'b0;
        #2;
        exp_irq = 0; exp_src = 0; exp_lvl = 0;
        check("R1 asynchronous reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule